// File: doc/BRIEF.md
# Serial Sequential-Access Bit Memory

This block is a one-bit-wide store that is addressed only in sequence. It is meant for streams of voice samples. There is no address bus. An internal pointer returns to location zero on a rising edge of the address-strobe input, provided the data input is low at that moment. The pointer then moves forward by one location on each rising edge of the step input. The direction input selects whether a step stores the incoming bit or moves the read pointer forward. The chip select is active low and parks the block when it is high.

The end flag lets several of these blocks form a chain. While the block is selected in write mode, the flag rises once the final location has been written and stays high. In read mode, the flag gives a single-cycle pulse when the final location has been read past. While the block is deselected, the flag repeats the direction input. After reset, reading is locked out until one write burst has finished. The bidirectional data pad is split into `data_in`, `data_out` and an output enable `data_oe`; when `data_oe` is low, the pad is high-impedance.

All five control and data inputs are brought onto `clk` through a synchroniser. A level change shows at the outputs two clock edges after it is applied. A strobe or step event takes effect on the third clock edge.

Top module: `seq_bit_store`

## Requirements
- R1: While `cs_n` is 1, `data_oe` is 0 and `end_flag` equals the synchronised `wr_sel`.
- R2: A rising edge of `addr_stb` while selected with `data_in` = 0 returns the pointer to location 0 and clears the held write end flag. A rising edge with `data_in` = 1 changes neither the pointer nor the flag.
- R3: While selected with `wr_sel` = 1, each rising edge of `step_clk` stores `data_in` at the pointer and advances the pointer by one.
- R4: From reset until a write burst has completed, `data_oe` stays 0 and read-mode steps neither advance the pointer nor pulse `end_flag`.
- R5: A write burst completes when at least one bit has been stored and the block then leaves write mode, either through `wr_sel` = 0 or `cs_n` = 1. Read enable is then set, and only reset clears it.
- R6: While selected with `wr_sel` = 0 and read enabled, `data_oe` is 1 and `data_out` is the bit stored at the pointer.
- R7: In write mode, `end_flag` rises with the step that stores location DEPTH-1. It stays at 1 until a valid clearing strobe.
- R8: In read mode, the step taken at location DEPTH-1 makes `end_flag` 1 for exactly one clock cycle.
- R9: Once location DEPTH-1 has been consumed, further steps are ignored: nothing is written, the pointer stays put, and no further read pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low (the board ties it low with a pull-down) |
| wr_sel | input | 1 | Direction: 1 write, 0 read |
| addr_stb | input | 1 | Address strobe; a rising edge with data low restarts the pointer |
| step_clk | input | 1 | Increment clock; a rising edge steps the pointer |
| data_in | input | 1 | Data pad input |
| data_out | output | 1 | Data pad output value |
| data_oe | output | 1 | Data pad drive enable; 0 means high-impedance |
| end_flag | output | 1 | End-of-page / cascade flag |

## Verification
The bench fills the whole store from a table and reads it back. It then pushes at the end of the array with an extra step, which catches a pointer that wraps or writes past the end. Such a design would corrupt location DEPTH-1 or pulse the read flag a second time.

Strobes with the data line high would, in a design that ignored the data line, send the pointer back to zero or drop the held write flag. Reads attempted before any write would expose a design that enables the pad too early. Deselecting and reselecting after a completed burst would catch a read enable that is not sticky. Running a reset after all of this confirms that reset alone clears the read enable.

// File: rtl/seq_bit_pkg.sv
package seq_bit_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_RD  = 2'd1,
    MODE_WR  = 2'd2
  } mode_e;

  function automatic mode_e mode_of(input logic cs_n, input logic wr);
    if (cs_n)    return MODE_OFF;
    else if (wr) return MODE_WR;
    else         return MODE_RD;
  endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/addr_seq.sv
module addr_seq #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_end,
  output logic          taken,
  output logic          last_take
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          end_q, end_d;

  assign taken     = step && !end_q && !clear;
  assign last_take = taken && (addr_q == LAST);

  always_comb begin
    addr_d = addr_q;
    end_d  = end_q;
    if (clear) begin
      addr_d = '0;
      end_d  = 1'b0;
    end else if (taken) begin
      if (addr_q == LAST) end_d  = 1'b1;
      else                addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      end_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      end_q  <= end_d;
    end
  end

  assign addr   = addr_q;
  assign at_end = end_q;

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (addr == '0 && !at_end));

  p_step_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !at_end && addr != LAST) |=> addr == $past(addr) + 1'b1);

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !clear) |=> ($stable(addr) && at_end));

endmodule

// File: rtl/bit_array.sv
module bit_array #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          wbit,
  output logic          rbit
);

  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wbit;
  end

  assign rbit = cells[addr];

endmodule

// File: rtl/seq_bit_store.sv
module seq_bit_store
  import seq_bit_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_sel,
  input  logic addr_stb,
  input  logic step_clk,
  input  logic data_in,
  output logic data_out,
  output logic data_oe,
  output logic end_flag
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // synchronised inputs: {data, step, strobe, wr, cs_n}
  logic [4:0] sync_v;
  logic       cs_s, wr_s, stb_s, stp_s, din_s;

  bit_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b00001)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({data_in, step_clk, addr_stb, wr_sel, cs_n}),
    .dout (sync_v)
  );

  assign {din_s, stp_s, stb_s, wr_s, cs_s} = sync_v;

  logic  stb_q, stp_q;
  logic  stb_rise, stp_rise;
  mode_e mode;
  logic  clear, adv;
  logic  taken, last_take, at_end;
  logic  we, rbit;
  logic [AW-1:0] addr;

  logic rd_en_q, rd_en_d;
  logic pend_q, pend_d;
  logic hold_q, hold_d;
  logic pulse_q, pulse_d;

  assign stb_rise = stb_s && !stb_q;
  assign stp_rise = stp_s && !stp_q;
  assign mode     = mode_of(cs_s, wr_s);
  assign clear    = (mode != MODE_OFF) && stb_rise && !din_s;
  assign adv      = stp_rise && ((mode == MODE_WR) || (mode == MODE_RD && rd_en_q));
  assign we       = taken && (mode == MODE_WR);

  addr_seq #(.DEPTH(DEPTH), .AW(AW)) i_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .step     (adv),
    .addr     (addr),
    .at_end   (at_end),
    .taken    (taken),
    .last_take(last_take)
  );

  bit_array #(.DEPTH(DEPTH), .AW(AW)) i_array (
    .clk (clk),
    .we  (we),
    .addr(addr),
    .wbit(din_s),
    .rbit(rbit)
  );

  always_comb begin
    rd_en_d = rd_en_q;
    pend_d  = pend_q;
    hold_d  = hold_q;
    pulse_d = last_take && (mode == MODE_RD);
    if (we) pend_d = 1'b1;
    if (pend_q && mode != MODE_WR) begin
      rd_en_d = 1'b1;
      pend_d  = 1'b0;
    end
    if (clear)                               hold_d = 1'b0;
    else if (last_take && mode == MODE_WR)   hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      stp_q   <= 1'b0;
      rd_en_q <= 1'b0;
      pend_q  <= 1'b0;
      hold_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      stb_q   <= stb_s;
      stp_q   <= stp_s;
      rd_en_q <= rd_en_d;
      pend_q  <= pend_d;
      hold_q  <= hold_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    data_oe  = 1'b0;
    end_flag = wr_s;
    case (mode)
      MODE_WR: end_flag = hold_q;
      MODE_RD: begin
        end_flag = pulse_q;
        data_oe  = rd_en_q;
      end
      default: ;
    endcase
  end

  assign data_out = data_oe ? rbit : 1'b0;

  p_rden_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_q |=> rd_en_q);

  p_rden_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en_q) |-> $past(pend_q));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  p_hold_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !clear) |=> hold_q);

  p_no_write_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |-> !we);

endmodule

// File: tb/test_seq_bit_store.sv
`timescale 1ns/1ps
module test_seq_bit_store;

  localparam int DEPTH = 16;

  // entry: {data bit, end flag expected after its step}
  localparam logic [1:0] VEC [DEPTH] = '{
    2'b10, 2'b00, 2'b10, 2'b10, 2'b00, 2'b00, 2'b10, 2'b00,
    2'b10, 2'b10, 2'b10, 2'b00, 2'b00, 2'b10, 2'b00, 2'b11
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, wr_sel, addr_stb, step_clk, data_in;
  logic data_out, data_oe, end_flag;
  int   n_chk = 0, n_bad = 0;
  logic snap;

  always #4 clk = ~clk;

  seq_bit_store #(.DEPTH(DEPTH)) i_seq_bit_store (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_sel(wr_sel),
    .addr_stb(addr_stb), .step_clk(step_clk), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .end_flag(end_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // rising step edge; snap holds end_flag on the cycle after the action edge
  task automatic step(input logic d);
    data_in  = d;
    step_clk = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    snap = end_flag;
    step_clk = 1'b0;
    settle();
  endtask

  task automatic strobe(input logic d);
    data_in  = d;
    addr_stb = 1'b1;
    settle();
    addr_stb = 1'b0;
    settle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    cs_n = 1'b1; wr_sel = 1'b0; addr_stb = 1'b0; step_clk = 1'b0; data_in = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: deselected state
    check("R1 oe deselected", data_oe, 1'b0);
    check("R1 flag follows wr=0", end_flag, 1'b0);
    wr_sel = 1'b1; settle();
    check("R1 flag follows wr=1", end_flag, 1'b1);
    wr_sel = 1'b0; settle();
    check("R1 flag follows wr back to 0", end_flag, 1'b0);

    // R4: reads locked before any write
    cs_n = 1'b0; settle();
    check("R4 oe blocked after reset", data_oe, 1'b0);
    strobe(1'b0);
    step(1'b0);
    check("R4 no read pulse while locked", snap, 1'b0);
    check("R4 oe still blocked", data_oe, 1'b0);

    // R3/R7: fill array from the table
    wr_sel = 1'b1; settle();
    check("R7 flag low before writes", end_flag, 1'b0);
    strobe(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      step(VEC[i][1]);
      check("R7 write end flag", snap, VEC[i][0]);
      check("R3 oe off while writing", data_oe, 1'b0);
    end
    settle();
    check("R7 flag held", end_flag, 1'b1);
    // R9: extra write step must not touch last cell
    step(~VEC[DEPTH-1][1]);
    check("R9 flag held after extra step", end_flag, 1'b1);
    // R2: strobe with data high ignored
    strobe(1'b1);
    check("R2 data-high strobe keeps flag", end_flag, 1'b1);
    strobe(1'b0);
    check("R7 valid strobe clears flag", end_flag, 1'b0);

    // R5/R6: leave write mode, read back
    wr_sel = 1'b0; settle();
    check("R5 read enabled after burst", data_oe, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R6 read data", data_out, VEC[i][1]);
      step(1'b0);
      check("R8 read pulse", snap, VEC[i][0]);
      check("R8 pulse is single cycle", end_flag, 1'b0);
    end
    check("R9 last cell intact", data_out, VEC[DEPTH-1][1]);
    step(1'b0);
    check("R9 no second pulse", snap, 1'b0);
    check("R9 pointer saturated", data_out, VEC[DEPTH-1][1]);

    // R2: restart and data-high strobe
    strobe(1'b0);
    check("R2 pointer back to 0", data_out, VEC[0][1]);
    step(1'b0);
    check("R6 pointer at 1", data_out, VEC[1][1]);
    strobe(1'b1);
    check("R2 data-high strobe keeps pointer", data_out, VEC[1][1]);

    // R1/R5: deselect then reselect
    cs_n = 1'b1; settle();
    check("R1 oe off when deselected", data_oe, 1'b0);
    check("R1 flag follows wr when deselected", end_flag, 1'b0);
    cs_n = 1'b0; settle();
    check("R5 read enable sticky", data_oe, 1'b1);
    check("R6 data after reselect", data_out, VEC[1][1]);

    // R4/R5: only reset clears read enable
    do_reset();
    check("R4 reset relocks reads", data_oe, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule